// File: doc/BRIEF.md
# Buffered SPI Master

This block is an SPI master that moves a whole block of characters per command. Software fills an internal transmit buffer of up to 64 characters, writes the character count, and sets the start bit of the command register. The block then shifts every character out on `sdo_o` under a clock it generates on `sck_o`. At the same time it captures one character per transmitted character from `sdi_i` into an internal receive buffer. If internal loopback is selected, it captures its own output instead of `sdi_i`.

Completion and errors are reported through an event register whose bits are cleared by writing ones. A mask register selects which events drive `irq_o`. A mode register sets the clock idle level, clock phase, bit order, character length (1 to 16 bits), a 4-bit prescaler with an optional divide-by-16 stage, loopback, master select and enable. Chip select is left to surrounding logic.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the mode, event, mask, transmit count and receive count registers read 0, and `sck_o`, `sdo_o` and `irq_o` are 0.
- R2: With `bus_addr[6]`=0, low address bits select a register: 0 mode, 1 command, 2 event, 3 mask, 4 transmit count, 5 receive count. The command register reads 0. The receive count cannot be written. With `bus_addr[6]`=1, writes load transmit buffer entry `bus_addr[5:0]` and reads return receive buffer entry `bus_addr[5:0]`.
- R3: Mode bits: 14 loopback, 13 clock idle high, 12 clock phase, 11 divide-by-16, 10 MSB first, 9 master, 8 enable, 7:4 character length minus one, 3:0 prescale. Writing command bit 7 while enabled, master and idle, with a count of 1 to 64, sends that many characters. At the end the receive count equals the transmit count.
- R4: Each half SCLK period lasts (prescale+1)×(16 if divide-by-16 else 1) clocks. Outside a transfer `sck_o` sits at the idle level and `sdo_o` is 0. Each character produces 2×length SCLK transitions. With phase 0, SCLK starts at the idle level in each bit. With phase 1, SCLK leaves the idle level at the start of each bit.
- R5: With bit 10 set, bits go out most significant first. With bit 10 clear, they go out least significant first. The bit on `sdo_o` is stable at the mid-bit SCLK edge.
- R6: In loopback the receive buffer equals the transmit buffer masked to the character length, for every length from 4 to 16.
- R7: Transmit-done (event bit 1) and receive-done (event bit 0) are raised together, exactly 2×length×count×half-period clocks after the clock edge that accepts the start.
- R8: A start while disabled, not master, or in a transfer is ignored and sets the rejected-start event (bit 2). A transfer already running completes normally.
- R9: A start with a transmit count of 0 or above 64 is ignored and sets the underflow event (bit 4).
- R10: Writing ones to the event register clears those bits and leaves the others.
- R11: `irq_o` is high exactly when some event bit and its mask bit are both set.
- R12: During a transfer, writes to the mode register, the transmit count and the transmit buffer are ignored.
- R13: With loopback off, `sdi_i` is sampled at the mid-bit SCLK edge into the receive character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | 7 | Register bus address |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data (combinational) |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so a readback is due in the same cycle the address is applied. A write, including a rejected start, shows its effect one edge after the strobe. Completion is due exactly 2×length×count×(prescale+1)×(1 or 16) edges after the accepting edge. The bench polls the event register at every falling edge after the start and compares the number of edges it counted with that figure, for each configuration in its table. SCLK transitions and mid-bit data are counted and captured by a monitor on `sck_o` and compared with the transmit pattern in the selected bit order.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int MB_LOOP   = 14;
    localparam int MB_CPOL   = 13;
    localparam int MB_CPHA   = 12;
    localparam int MB_DIV16  = 11;
    localparam int MB_MSB    = 10;
    localparam int MB_MASTER = 9;
    localparam int MB_EN     = 8;

    localparam int EV_UFL = 4;
    localparam int EV_REJ = 2;
    localparam int EV_TXD = 1;
    localparam int EV_RXD = 0;

    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_CMD  = 3'd1;
    localparam logic [2:0] RA_EVT  = 3'd2;
    localparam logic [2:0] RA_MASK = 3'd3;
    localparam logic [2:0] RA_TCNT = 3'd4;
    localparam logic [2:0] RA_RCNT = 3'd5;

    typedef struct packed {
        logic loop;
        logic cpol;
        logic cpha;
        logic msb;
    } spim_cfg_t;
endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [PS_W-1:0] presc_i,
    input  logic            div16_i,
    output logic            tick_o
);
    localparam int DIVW = PS_W + 5;

    logic [DIVW-1:0] cnt_d, cnt_q;
    logic [DIVW-1:0] lim;

    always_comb begin
        lim = DIVW'(presc_i) + DIVW'(1);
        if (div16_i) lim = lim << 4;
        tick_o = en_i && (cnt_q == lim - DIVW'(1));
        cnt_d  = (!en_i || tick_o) ? '0 : cnt_q + DIVW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spim_buf.sv
module spim_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CHAR_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int BW    = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  spim_cfg_t         cfg_i,
    input  logic [BW-1:0]     len_m1_i,
    input  logic [CW-1:0]     count_i,
    input  logic              tick_i,
    input  logic [CHAR_W-1:0] txw_i,
    input  logic              sdi_i,
    output logic [AW-1:0]     chr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              rxwe_o,
    output logic [CHAR_W-1:0] rxdata_o,
    output logic              sck_o,
    output logic              sdo_o
);
    typedef struct packed {
        logic              run;
        logic              half;
        logic [BW-1:0]     bitn;
        logic [AW-1:0]     chr;
        logic [CHAR_W-1:0] rx;
    } eng_t;

    eng_t st_d, st_q;
    logic [BW-1:0] pos;
    logic          sin;

    always_comb begin
        pos    = cfg_i.msb ? (len_m1_i - st_q.bitn) : st_q.bitn;
        sdo_o  = st_q.run ? txw_i[pos] : 1'b0;
        sin    = cfg_i.loop ? sdo_o : sdi_i;
        sck_o  = st_q.run ? (cfg_i.cpol ^ (cfg_i.cpha ? ~st_q.half : st_q.half))
                          : cfg_i.cpol;
        st_d   = st_q;
        done_o = 1'b0;
        rxwe_o = 1'b0;
        if (!st_q.run) begin
            if (start_i) begin
                st_d.run  = 1'b1;
                st_d.half = 1'b0;
                st_d.bitn = '0;
                st_d.chr  = '0;
                st_d.rx   = '0;
            end
        end else if (tick_i) begin
            if (!st_q.half) begin
                // mid-bit edge: capture the incoming bit
                st_d.rx[pos] = sin;
                st_d.half    = 1'b1;
            end else begin
                st_d.half = 1'b0;
                if (st_q.bitn == len_m1_i) begin
                    st_d.bitn = '0;
                    st_d.rx   = '0;
                    rxwe_o    = 1'b1;
                    if (CW'(st_q.chr) == count_i - CW'(1)) begin
                        st_d.run = 1'b0;
                        done_o   = 1'b1;
                    end else begin
                        st_d.chr = st_q.chr + AW'(1);
                    end
                end else begin
                    st_d.bitn = st_q.bitn + BW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chr_o    = st_q.chr;
    assign busy_o   = st_q.run;
    assign rxdata_o = st_q.rx;
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spim_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CHAR_W = 16,
    parameter int PS_W   = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int BW    = $clog2(CHAR_W)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [AW:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        sck_o,
    output logic        sdo_o,
    input  logic        sdi_i,
    output logic        irq_o
);
    localparam logic [5:0] EV_IMPL = 6'b010111;

    typedef struct packed {
        logic [14:0]   mode;
        logic [5:0]    evt;
        logic [5:0]    mask;
        logic [CW-1:0] tcnt;
        logic [CW-1:0] rcnt;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              busy, done, tick, start, txwe, rxwe;
    logic [AW-1:0]     chr;
    logic [CHAR_W-1:0] txw, rxw, rxrd;
    logic [5:0]        ev_set, ev_clr;
    logic              is_buf;
    logic [2:0]        rsel;
    spim_cfg_t         cfg;
    logic              unused_bits;

    assign is_buf      = bus_addr[AW];
    assign rsel        = bus_addr[2:0];
    assign unused_bits = ^bus_wdata[15:CW];

    always_comb begin
        cfg.loop = regs_q.mode[MB_LOOP];
        cfg.cpol = regs_q.mode[MB_CPOL];
        cfg.cpha = regs_q.mode[MB_CPHA];
        cfg.msb  = regs_q.mode[MB_MSB];
    end

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        ev_set = '0;
        ev_clr = '0;
        txwe   = bus_we && is_buf && !busy;
        if (bus_we && !is_buf) begin
            case (rsel)
                RA_MODE: if (!busy) regs_d.mode = bus_wdata[14:0];
                RA_CMD: if (bus_wdata[7]) begin
                    if (!regs_q.mode[MB_EN] || !regs_q.mode[MB_MASTER] || busy)
                        ev_set[EV_REJ] = 1'b1;
                    else if (regs_q.tcnt == '0 || regs_q.tcnt > CW'(DEPTH))
                        ev_set[EV_UFL] = 1'b1;
                    else begin
                        start       = 1'b1;
                        regs_d.rcnt = '0;
                    end
                end
                RA_EVT:  ev_clr = bus_wdata[5:0];
                RA_MASK: regs_d.mask = bus_wdata[5:0];
                RA_TCNT: if (!busy) regs_d.tcnt = bus_wdata[CW-1:0];
                default: ;
            endcase
        end
        if (done) begin
            ev_set[EV_TXD] = 1'b1;
            ev_set[EV_RXD] = 1'b1;
            regs_d.rcnt    = regs_q.tcnt;
        end
        // a new event wins over a clear in the same cycle
        regs_d.evt = ((regs_q.evt & ~ev_clr) | ev_set) & EV_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (is_buf) bus_rdata = 16'(rxrd);
        else begin
            case (rsel)
                RA_MODE: bus_rdata = {1'b0, regs_q.mode};
                RA_EVT:  bus_rdata = 16'(regs_q.evt);
                RA_MASK: bus_rdata = 16'(regs_q.mask);
                RA_TCNT: bus_rdata = 16'(regs_q.tcnt);
                RA_RCNT: bus_rdata = 16'(regs_q.rcnt);
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = |(regs_q.evt & regs_q.mask);

    spim_tick #(.PS_W(PS_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (busy),
        .presc_i (regs_q.mode[PS_W-1:0]),
        .div16_i (regs_q.mode[MB_DIV16]),
        .tick_o  (tick)
    );

    spim_buf #(.DEPTH(DEPTH), .W(CHAR_W)) u_txbuf (
        .clk     (clk),
        .we_i    (txwe),
        .waddr_i (bus_addr[AW-1:0]),
        .wdata_i (CHAR_W'(bus_wdata)),
        .raddr_i (chr),
        .rdata_o (txw)
    );

    spim_buf #(.DEPTH(DEPTH), .W(CHAR_W)) u_rxbuf (
        .clk     (clk),
        .we_i    (rxwe),
        .waddr_i (chr),
        .wdata_i (rxw),
        .raddr_i (bus_addr[AW-1:0]),
        .rdata_o (rxrd)
    );

    spim_engine #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cfg_i    (cfg),
        .len_m1_i (regs_q.mode[4 +: BW]),
        .count_i  (regs_q.tcnt),
        .tick_i   (tick),
        .txw_i    (txw),
        .sdi_i    (sdi_i),
        .chr_o    (chr),
        .busy_o   (busy),
        .done_o   (done),
        .rxwe_o   (rxwe),
        .rxdata_o (rxw),
        .sck_o    (sck_o),
        .sdo_o    (sdo_o)
    );
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          sck,
    input logic          sdo,
    input logic [14:0]   mode,
    input logic [5:0]    evt,
    input logic [CW-1:0] tcnt,
    input logic [CW-1:0] rcnt
);
    AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == mode[13]); // R4
    AST_IDLE_SDO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdo); // R4
    AST_DONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt[1:0] == 2'b11); // R7
    AST_RCNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rcnt == tcnt); // R3
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mode) && $stable(tcnt)); // R12
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tcnt != '0 && tcnt <= CW'(DEPTH)); // R9
endmodule

bind spi_burst_master spim_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .sck   (sck_o),
    .sdo   (sdo_o),
    .mode  (regs_q.mode),
    .evt   (regs_q.evt),
    .tcnt  (regs_q.tcnt),
    .rcnt  (regs_q.rcnt)
);

// File: tb/tb_spi_burst_master.sv
`timescale 1ns/1ps
module tb_spi_burst_master;
    localparam logic [2:0] A_MODE = 3'd0, A_CMD = 3'd1, A_EVT = 3'd2,
                           A_MASK = 3'd3, A_TCNT = 3'd4, A_RCNT = 3'd5;

    // row: [18:15] len-1, [14] cpol, [13] cpha, [12] msb, [11] div16, [10:7] prescale, [6:0] count
    localparam logic [18:0] VEC [8] = '{
        {4'd7,  1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 7'd4},
        {4'd7,  1'b1, 1'b1, 1'b1, 1'b0, 4'd1, 7'd3},
        {4'd15, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 7'd2},
        {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 7'd5},
        {4'd11, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 7'd1},
        {4'd4,  1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 7'd2},
        {4'd15, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 7'd64},
        {4'd8,  1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 7'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck_o, sdo_o, irq_o;
    logic        sdi_i = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic cap_pol = 1'b0, cap_pha = 1'b0;
    logic cap [4096];
    int   ncap = 0;
    int   nedge = 0;

    always #4 clk = ~clk;

    spi_burst_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sck_o     (sck_o),
        .sdo_o     (sdo_o),
        .sdi_i     (sdi_i),
        .irq_o     (irq_o)
    );

    // SCLK monitor: counts transitions, captures sdo at the mid-bit edge
    always @(sck_o) begin
        if (sck_o === (cap_pha ? cap_pol : ~cap_pol)) begin
            cap[ncap % 4096] = sdo_o;
            ncap++;
        end
        nedge++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] pat(input int i, input int r);
        return 16'((i * 32'h2D9B) ^ (r * 32'h7A31) ^ 32'h5C3A);
    endfunction

    task automatic run_xfer(input int r, input logic [3:0] lm1, input logic cpol,
                            input logic cpha, input logic msb, input logic div16,
                            input logic [3:0] ps, input int cnt, input logic loop);
        int len, lim, cyc, e0, c0, exp_cyc;
        logic [15:0] msk, mw, v, p0, ce, ca;
        len = int'(lm1) + 1;
        lim = (int'(ps) + 1) * (div16 ? 16 : 1);
        msk = 16'((32'd1 << len) - 1);
        mw  = {1'b0, loop, cpol, cpha, div16, msb, 1'b1, 1'b1, lm1, ps};
        wr({4'd0, A_MODE}, mw);
        for (int i = 0; i < cnt; i++) wr(7'(64 + i), pat(i, r));
        wr({4'd0, A_TCNT}, 16'(cnt));
        wr({4'd0, A_EVT}, 16'h003F);
        cap_pol = cpol; cap_pha = cpha;
        e0 = nedge; c0 = ncap;
        wr({4'd0, A_CMD}, 16'h0080);
        cyc = 0;
        rd({4'd0, A_EVT}, v);
        while (!v[1] && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            rd({4'd0, A_EVT}, v);
        end
        exp_cyc = 2 * len * cnt * lim;
        chk($sformatf("R7 done cycle row %0d", r), cyc, exp_cyc);
        chk($sformatf("R7 events row %0d", r), v, 16'h0003);
        rd({4'd0, A_RCNT}, v);
        chk($sformatf("R3 rx count row %0d", r), v, 16'(cnt));
        chk($sformatf("R4 sclk edges row %0d", r), nedge - e0, 2 * len * cnt);
        p0 = pat(0, r);
        ce = '0; ca = '0;
        for (int j = 0; j < len; j++) begin
            ce[j] = msb ? p0[len - 1 - j] : p0[j];
            ca[j] = cap[(c0 + j) % 4096];
        end
        chk($sformatf("R5 wire order row %0d", r), ca, ce);
        for (int i = 0; i < cnt; i++) begin
            rd(7'(64 + i), v);
            if (loop) chk($sformatf("R6 loopback row %0d char %0d", r, i), v, pat(i, r) & msk);
            else      chk($sformatf("R13 sdi capture row %0d char %0d", r, i), v, sdi_i ? msk : 16'h0);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd({4'd0, A_MODE}, v); chk("R1 mode", v, 0);
        rd({4'd0, A_EVT},  v); chk("R1 event", v, 0);
        rd({4'd0, A_MASK}, v); chk("R1 mask", v, 0);
        rd({4'd0, A_TCNT}, v); chk("R1 tcnt", v, 0);
        rd({4'd0, A_RCNT}, v); chk("R1 rcnt", v, 0);
        chk("R1 pins", {sck_o, sdo_o, irq_o}, 3'b000);

        // R2 register map
        wr({4'd0, A_MODE}, 16'hFABC);
        rd({4'd0, A_MODE}, v); chk("R2 mode readback", v, 16'h7ABC);
        wr({4'd0, A_TCNT}, 16'h007F);
        rd({4'd0, A_TCNT}, v); chk("R2 tcnt readback", v, 16'h007F);
        wr({4'd0, A_RCNT}, 16'h0005);
        rd({4'd0, A_RCNT}, v); chk("R2 rcnt read only", v, 0);
        rd({4'd0, A_CMD}, v);  chk("R2 command reads 0", v, 0);

        // table of configurations, loopback
        for (int r = 0; r < 8; r++) begin
            logic [18:0] t;
            t = VEC[r];
            run_xfer(r, t[18:15], t[14], t[13], t[12], t[11], t[10:7], int'(t[6:0]), 1'b1);
        end

        // R6 every length 4..16
        for (int l = 4; l <= 16; l++)
            run_xfer(20 + l, 4'(l - 1), l[0], l[1], l[2], 1'b0, 4'd0, 2, 1'b1);

        // R13 external input, loopback off
        sdi_i = 1'b1;
        run_xfer(40, 4'd9, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 3, 1'b0);
        sdi_i = 1'b0;
        run_xfer(41, 4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 2, 1'b0);

        // R8 rejected starts: disabled, then not master
        wr({4'd0, A_MODE}, 16'h0270);
        wr({4'd0, A_TCNT}, 16'h0002);
        wr({4'd0, A_EVT}, 16'h003F);
        e0 = nedge;
        wr({4'd0, A_CMD}, 16'h0080);
        rd({4'd0, A_EVT}, v); chk("R8 start while disabled", v, 16'h0004);
        repeat (40) @(negedge clk);
        chk("R8 no sclk when disabled", nedge - e0, 0);
        wr({4'd0, A_MODE}, 16'h0170);
        wr({4'd0, A_EVT}, 16'h003F);
        wr({4'd0, A_CMD}, 16'h0080);
        rd({4'd0, A_EVT}, v); chk("R8 start when not master", v, 16'h0004);

        // R9 count 0 and count 65
        wr({4'd0, A_MODE}, 16'h0370);
        wr({4'd0, A_TCNT}, 16'h0000);
        wr({4'd0, A_EVT}, 16'h003F);
        e0 = nedge;
        wr({4'd0, A_CMD}, 16'h0080);
        rd({4'd0, A_EVT}, v); chk("R9 count zero", v, 16'h0010);
        repeat (20) @(negedge clk);
        chk("R9 no sclk on count zero", nedge - e0, 0);
        wr({4'd0, A_TCNT}, 16'd65);
        wr({4'd0, A_EVT}, 16'h003F);
        wr({4'd0, A_CMD}, 16'h0080);
        rd({4'd0, A_EVT}, v); chk("R9 count 65", v, 16'h0010);

        // R8/R12 activity during a transfer
        wr({4'd0, A_MODE}, 16'h4771);
        for (int i = 0; i < 3; i++) wr(7'(64 + i), pat(i, 50));
        wr({4'd0, A_TCNT}, 16'h0003);
        wr({4'd0, A_EVT}, 16'h003F);
        wr({4'd0, A_CMD}, 16'h0080);
        repeat (6) @(negedge clk);
        wr({4'd0, A_CMD}, 16'h0080);
        wr({4'd0, A_MODE}, 16'h0000);
        wr({4'd0, A_TCNT}, 16'h0005);
        wr(7'd64, 16'h0000);
        rd({4'd0, A_EVT}, v); chk("R8 start during transfer", v, 16'h0004);
        for (int k = 0; k < 500 && !v[1]; k++) begin
            @(negedge clk);
            rd({4'd0, A_EVT}, v);
        end
        chk("R8 running transfer completes", v, 16'h0007);
        rd({4'd0, A_MODE}, v); chk("R12 mode held", v, 16'h4771);
        rd({4'd0, A_TCNT}, v); chk("R12 tcnt held", v, 16'h0003);
        rd({4'd0, A_RCNT}, v); chk("R12 rcnt", v, 16'h0003);
        rd(7'd64, v);          chk("R12 tx buffer held", v, pat(0, 50) & 16'h00FF);

        // R10 / R11 clear and interrupt
        chk("R11 irq masked off", irq_o, 1'b0);
        wr({4'd0, A_MASK}, 16'h0002);
        chk("R11 irq on done", irq_o, 1'b1);
        wr({4'd0, A_EVT}, 16'h0002);
        rd({4'd0, A_EVT}, v); chk("R10 clear one bit", v, 16'h0005);
        chk("R11 irq after clear", irq_o, 1'b0);
        wr({4'd0, A_MASK}, 16'h0004);
        chk("R11 irq on rejected start", irq_o, 1'b1);
        wr({4'd0, A_EVT}, 16'h003F);
        rd({4'd0, A_EVT}, v); chk("R10 clear all", v, 16'h0000);
        chk("R11 irq idle", irq_o, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule